// File: doc/BRIEF.md
# Register-Mapped 37-Pin GPIO Expander Core

This block is the register file and pin control of a general-purpose I/O expander. A host reaches it through a small register port with a 5-bit index and 16-bit data. Writes take effect on the clock edge where write enable is high. Reads are combinational from the current index.

Each of the 37 pins has three bits: a function-select bit, a direction bit and an output latch. A pin drives its pad only when three conditions hold together: the global start bit is set, the pin is selected as GPIO, and its direction is output. Pad inputs pass through a synchronizer before they reach the data registers. A read of a data register returns the synchronized pad level for input pins and the latch value for output pins.

A fixed identification value lets the host detect that the device is present. Pins 32 to 36 have no separate direction register. Their direction bits share the third select register with their select bits.

Top module: `gpx_core`

## Requirements
- R1: After reset the start bit and all latches and select bits are 0, and every direction bit is 1 (input). Register 4 reads 0x03E0, registers 5 and 6 read 0xFFFF, and `pad_oe` is all zero.
- R2: Register 1 always reads 0x0370. Writes to it have no effect.
- R3: Registers 2 and 3 hold the select bits for pins 0–15 and 16–31, at bit position pin mod 16. Bits 0–4 of register 4 select pins 32–36. Bits 10–15 of register 4 read 0.
- R4: Registers 5 and 6 hold the direction bits for pins 0–15 and 16–31, at bit position pin mod 16, where 1 means input and 0 means output. No pin with direction 1 has its output enable set.
- R5: The direction bit of pin 32+k (k = 0..4) is bit 5+k of register 4.
- R6: Bit 1 of register 0 is the start bit. All other bits of register 0 read 0.
- R7: `pad_oe[i]` is high exactly when the start bit is 1, select bit i is 1 and direction bit i is 0. `pad_out[i]` equals latch i while `pad_oe[i]` is high and is 0 otherwise. Both follow a register write in the cycle after its clock edge.
- R8: Registers 0x1C, 0x1D and 0x1E return pin data at bit position pin mod 16. Bits 5–15 of 0x1E read 0. An input pin returns its pad level, and a pad change becomes visible after two clock edges. An output pin returns its latch.
- R9: A write to a data register updates only the output latches. For an input pin the read value is unaffected, and the written value appears once the pin becomes an output.
- R10: Every index other than 0–6 and 0x1C–0x1E reads 0. Writes to such an index change no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Register index |
| reg_wr_en | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| pad_in | input | 37 | Pad input levels (asynchronous) |
| pad_oe | output | 37 | Per-pin output enable |
| pad_out | output | 37 | Per-pin output value |

## Verification
Two functions can act on the same pin in the same cycle: a latch write from the host and the pad-input path feeding a read of the same data register. The bench writes a data register while the addressed pin is still an input. The read must still show the synchronized pad level, and the written latch must appear only after the direction flips to output. Two further cases are provoked: a pad change timed against the two-stage synchronizer, where the read is judged on both sides of the second edge, and a single write to register 4 that changes select and direction of the high pins at once, judged on `pad_oe` and `pad_out` in the following cycle.

// File: rtl/gpx_pkg.sv
// Package: register index map and fixed constants of the GPIO expander core.
// Assumes a 5-bit index and 16-bit data on the register port.
package gpx_pkg;
    localparam int unsigned REG_AW     = 5;
    localparam int unsigned REG_DW     = 16;
    localparam int unsigned BANK_W     = 16;
    localparam logic [REG_AW-1:0] ADDR_CTRL  = 5'h00;
    localparam logic [REG_AW-1:0] ADDR_ID    = 5'h01;
    localparam logic [REG_AW-1:0] ADDR_SEL0  = 5'h02;
    localparam logic [REG_AW-1:0] ADDR_DIR0  = 5'h05;
    localparam logic [REG_AW-1:0] ADDR_DATA0 = 5'h1C;
    localparam logic [REG_DW-1:0] ID_VALUE   = 16'h0370;
    localparam int unsigned START_BIT  = 1;
    localparam int unsigned HI_DIR_OFS = 5;
endpackage

// File: rtl/gpx_sync.sv
// Module: multi-stage synchronizer for the asynchronous pad inputs.
// Assumes each bit is independent, so no bus coherency is needed.
module gpx_sync #(
    parameter int unsigned W      = 37,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // shift the pad levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '{default: '0};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpx_regfile.sv
// Module: writable state of the expander (start bit, select, direction, latches).
// Assumes the pin count leaves a partial last bank of at most HI_DIR_OFS pins,
// whose direction bits live in that bank's select register.
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter int unsigned NUM_PINS = 37
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   wr_addr,
    input  logic [REG_DW-1:0]   wr_data,
    output logic                start,
    output logic [NUM_PINS-1:0] sel,
    output logic [NUM_PINS-1:0] dir,
    output logic [NUM_PINS-1:0] lat
);
    localparam int unsigned NB  = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int unsigned FB  = NUM_PINS / BANK_W;
    localparam int unsigned REM = NUM_PINS - FB * BANK_W;

    logic start_q;

    // global start bit in the control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            start_q <= wr_data[START_BIT];
        end
    end
    assign start = start_q;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam int unsigned BW = (b < FB) ? BANK_W : REM;
        localparam int unsigned LO = b * BANK_W;
        localparam logic [REG_AW-1:0] A_SEL = REG_AW'(ADDR_SEL0 + b);
        localparam logic [REG_AW-1:0] A_DAT = REG_AW'(ADDR_DATA0 + b);
        logic [BW-1:0] sel_q;
        logic [BW-1:0] lat_q;

        // select bits of this bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q <= '0;
            end else if (wr_en && wr_addr == A_SEL) begin
                sel_q <= wr_data[BW-1:0];
            end
        end

        // output latches of this bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat_q <= '0;
            end else if (wr_en && wr_addr == A_DAT) begin
                lat_q <= wr_data[BW-1:0];
            end
        end

        assign sel[LO +: BW] = sel_q;
        assign lat[LO +: BW] = lat_q;

        if (b < FB) begin : g_full_dir
            localparam logic [REG_AW-1:0] A_DIR = REG_AW'(ADDR_DIR0 + b);
            logic [BW-1:0] dir_q;
            // direction register of a full bank, inputs after reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dir_q <= '1;
                end else if (wr_en && wr_addr == A_DIR) begin
                    dir_q <= wr_data;
                end
            end
            assign dir[LO +: BW] = dir_q;
        end else begin : g_packed_dir
            logic [BW-1:0] dir_q;
            // direction bits packed above the select bits of the partial bank
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dir_q <= '1;
                end else if (wr_en && wr_addr == A_SEL) begin
                    dir_q <= wr_data[HI_DIR_OFS +: BW];
                end
            end
            assign dir[LO +: BW] = dir_q;
        end
    end
endmodule

// File: rtl/gpx_pin_ctrl.sv
// Module: per-pin tri-state control and data-readback selection.
// Assumes all inputs are registered state, so outputs are glitch-safe per cycle.
module gpx_pin_ctrl #(
    parameter int unsigned NUM_PINS = 37
) (
    input  logic                start,
    input  logic [NUM_PINS-1:0] sel,
    input  logic [NUM_PINS-1:0] dir,
    input  logic [NUM_PINS-1:0] lat,
    input  logic [NUM_PINS-1:0] pin_sync,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pin_rd
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic drive;
        // enable the driver only for started, selected output pins
        assign drive      = start & sel[i] & ~dir[i];
        assign pad_oe[i]  = drive;
        assign pad_out[i] = drive & lat[i];
        // readback: pad level for inputs, latch for outputs
        assign pin_rd[i]  = dir[i] ? pin_sync[i] : lat[i];
    end
endmodule

// File: rtl/gpx_rd_mux.sv
// Module: combinational register read multiplexer.
// Assumes unimplemented indices return zero.
module gpx_rd_mux
    import gpx_pkg::*;
#(
    parameter int unsigned NUM_PINS = 37
) (
    input  logic [REG_AW-1:0]   rd_addr,
    input  logic                start,
    input  logic [NUM_PINS-1:0] sel,
    input  logic [NUM_PINS-1:0] dir,
    input  logic [NUM_PINS-1:0] pin_rd,
    output logic [REG_DW-1:0]   rd_data
);
    localparam int unsigned NB  = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int unsigned FB  = NUM_PINS / BANK_W;
    localparam int unsigned REM = NUM_PINS - FB * BANK_W;

    logic [REG_DW-1:0] word_sel [NB];
    logic [REG_DW-1:0] word_dat [NB];
    logic [REG_DW-1:0] word_dir [FB];

    for (genvar b = 0; b < NB; b++) begin : g_word
        localparam int unsigned LO = b * BANK_W;
        if (b < FB) begin : g_full
            assign word_sel[b] = sel[LO +: BANK_W];
            assign word_dat[b] = pin_rd[LO +: BANK_W];
            assign word_dir[b] = dir[LO +: BANK_W];
        end else begin : g_part
            logic [REG_DW-1:0] w_sel;
            logic [REG_DW-1:0] w_dat;
            // pack select and direction bits of the partial bank
            always_comb begin
                w_sel = '0;
                w_sel[REM-1:0] = sel[LO +: REM];
                w_sel[HI_DIR_OFS +: REM] = dir[LO +: REM];
            end
            // zero-extend the partial data word
            always_comb begin
                w_dat = '0;
                w_dat[REM-1:0] = pin_rd[LO +: REM];
            end
            assign word_sel[b] = w_sel;
            assign word_dat[b] = w_dat;
        end
    end

    // pick the word addressed by rd_addr
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_CTRL) rd_data[START_BIT] = start;
        if (rd_addr == ADDR_ID)   rd_data = ID_VALUE;
        for (int b = 0; b < int'(NB); b++) begin
            if (rd_addr == REG_AW'(ADDR_SEL0 + b))  rd_data = word_sel[b];
            if (rd_addr == REG_AW'(ADDR_DATA0 + b)) rd_data = word_dat[b];
        end
        for (int b = 0; b < int'(FB); b++) begin
            if (rd_addr == REG_AW'(ADDR_DIR0 + b)) rd_data = word_dir[b];
        end
    end
endmodule

// File: rtl/gpx_core.sv
// Module: top of the register-mapped GPIO expander core.
// Assumes a host that writes through reg_wr_en and reads combinationally.
module gpx_core
    import gpx_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 37,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [4:0]          reg_addr,
    input  logic                reg_wr_en,
    input  logic [15:0]         reg_wdata,
    output logic [15:0]         reg_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out
);
    logic                ctl_start;
    logic [NUM_PINS-1:0] pin_sel;
    logic [NUM_PINS-1:0] pin_dir;
    logic [NUM_PINS-1:0] pin_lat;
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] pin_rd;

    gpx_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    gpx_regfile #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .start   (ctl_start),
        .sel     (pin_sel),
        .dir     (pin_dir),
        .lat     (pin_lat)
    );

    gpx_pin_ctrl #(.NUM_PINS(NUM_PINS)) u_pins (
        .start    (ctl_start),
        .sel      (pin_sel),
        .dir      (pin_dir),
        .lat      (pin_lat),
        .pin_sync (pin_sync),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out),
        .pin_rd   (pin_rd)
    );

    gpx_rd_mux #(.NUM_PINS(NUM_PINS)) u_rd (
        .rd_addr (reg_addr),
        .start   (ctl_start),
        .sel     (pin_sel),
        .dir     (pin_dir),
        .pin_rd  (pin_rd),
        .rd_data (reg_rdata)
    );
endmodule

// File: rtl/gpx_core_chk.sv
// Module: assertion checker bound into gpx_core.
// Assumes synchronous active-low reset; all properties are disabled during reset.
module gpx_core_chk #(
    parameter int unsigned NUM_PINS = 37
) (
    input logic                clk,
    input logic                rst_n,
    input logic [4:0]          reg_addr,
    input logic                reg_wr_en,
    input logic [15:0]         reg_wdata,
    input logic [15:0]         reg_rdata,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic                start,
    input logic [NUM_PINS-1:0] dir,
    input logic [NUM_PINS-1:0] lat
);
    AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == 5'h01 |-> reg_rdata == 16'h0370); // R2
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr inside {[5'h07:5'h1B], 5'h1F}) |-> reg_rdata == 16'h0000); // R10
    AST_OE_ONLY_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & dir) == '0); // R4
    AST_OE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (|pad_oe) |-> start); // R7
    AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0); // R7
    AST_START_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 5'h00) |=> start == $past(reg_wdata[1])); // R6
    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 5'h1C) |=> lat[15:0] == $past(reg_wdata)); // R9
endmodule

bind gpx_core gpx_core_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .start     (ctl_start),
    .dir       (pin_dir),
    .lat       (pin_lat)
);

// File: tb/test_gpx_core.sv
`timescale 1ns/1ps
module test_gpx_core;
    localparam int NP = 37;
    localparam int NV = 19;
    // vector: {req[3:0], op(1=write), addr[4:0], data[15:0]}
    localparam logic [25:0] VEC [NV] = '{
        {4'd3,  1'b1, 5'h02, 16'hFFFF},   // R3
        {4'd3,  1'b1, 5'h03, 16'hFFFF},   // R3
        {4'd5,  1'b1, 5'h04, 16'h03FF},   // R5
        {4'd3,  1'b0, 5'h02, 16'hFFFF},   // R3
        {4'd3,  1'b0, 5'h03, 16'hFFFF},   // R3
        {4'd5,  1'b0, 5'h04, 16'h03FF},   // R5
        {4'd2,  1'b0, 5'h01, 16'h0370},   // R2
        {4'd2,  1'b1, 5'h01, 16'h1234},   // R2
        {4'd2,  1'b0, 5'h01, 16'h0370},   // R2
        {4'd4,  1'b1, 5'h05, 16'h00FF},   // R4
        {4'd4,  1'b0, 5'h05, 16'h00FF},   // R4
        {4'd4,  1'b1, 5'h06, 16'hF0F0},   // R4
        {4'd4,  1'b0, 5'h06, 16'hF0F0},   // R4
        {4'd6,  1'b1, 5'h00, 16'hFFFF},   // R6
        {4'd6,  1'b0, 5'h00, 16'h0002},   // R6
        {4'd10, 1'b1, 5'h07, 16'hABCD},   // R10
        {4'd10, 1'b0, 5'h07, 16'h0000},   // R10
        {4'd10, 1'b0, 5'h1F, 16'h0000},   // R10
        {4'd4,  1'b0, 5'h05, 16'h00FF}    // R4
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic          reg_wr_en = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pad_out;

    int n_chk = 0;
    int n_fail = 0;

    // bench model of the writable state, from the requirements
    logic          m_start;
    logic [NP-1:0] m_sel, m_dir, m_lat;

    always #5 clk = ~clk;

    gpx_core i_gpx_core (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_start = 1'b0; m_sel = '0; m_dir = '1; m_lat = '0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
        case (a)
            5'h00: m_start = d[1];
            5'h02: m_sel[15:0] = d;
            5'h03: m_sel[31:16] = d;
            5'h04: begin m_sel[36:32] = d[4:0]; m_dir[36:32] = d[9:5]; end
            5'h05: m_dir[15:0] = d;
            5'h06: m_dir[31:16] = d;
            5'h1C: m_lat[15:0] = d;
            5'h1D: m_lat[31:16] = d;
            5'h1E: m_lat[36:32] = d[4:0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] e, input string tag);
        reg_addr = a;
        #1;
        chk(tag, 64'(reg_rdata), 64'(e));
    endtask

    task automatic pads(input string tag);
        logic [NP-1:0] eoe;
        eoe = {NP{m_start}} & m_sel & ~m_dir;
        #1;
        chk({tag, " pad_oe"}, 64'(pad_oe), 64'(eoe));
        chk({tag, " pad_out"}, 64'(pad_out), 64'(eoe & m_lat));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(5'h00, 16'h0000, "R1 ctrl");
        rd(5'h02, 16'h0000, "R1 sel0");
        rd(5'h04, 16'h03E0, "R1 sel2/dirhi");
        rd(5'h05, 16'hFFFF, "R1 dir0");
        rd(5'h06, 16'hFFFF, "R1 dir1");
        rd(5'h1C, 16'h0000, "R1 data0");
        pads("R1 reset");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][21]) wr(VEC[i][20:16], VEC[i][15:0]);
            else rd(VEC[i][20:16], VEC[i][15:0], $sformatf("R%0d vec%0d", VEC[i][25:22], i));
        end
        pads("R7 after table");

        // R9 latch write, R8 readback mix of pads and latches
        wr(5'h1C, 16'hAAAA);
        rd(5'h1C, 16'hAA00, "R8 data0 mixed");
        pads("R7 latched");
        @(negedge clk);
        pad_in = 37'h1F_5555_5555;
        repeat (3) @(negedge clk);
        rd(5'h1C, 16'hAA55, "R8 data0 pads");
        rd(5'h1D, 16'h5050, "R8 data1 pads");
        rd(5'h1E, 16'h001F, "R8 data2 high inputs");
        // R8 two-edge synchronizer latency
        @(negedge clk);
        pad_in = 37'h1F_5555_5554;
        @(posedge clk); @(negedge clk);
        rd(5'h1C, 16'hAA55, "R8 one edge old");
        @(posedge clk); @(negedge clk);
        rd(5'h1C, 16'hAA54, "R8 two edges new");

        // R5 high pins to outputs via the packed register
        wr(5'h04, 16'h001F);
        rd(5'h04, 16'h001F, "R5 sel2 readback");
        pads("R5 high outputs");
        wr(5'h1E, 16'hFFFF);
        rd(5'h1E, 16'h001F, "R8 data2 upper zero");
        pads("R7 high driven");

        // R6/R7 start clear gates every driver
        wr(5'h00, 16'h0000);
        rd(5'h00, 16'h0000, "R6 start clear");
        pads("R7 start low");
        chk("R7 no drive", 64'(pad_oe), 64'(0));
        wr(5'h00, 16'h0002);
        wr(5'h02, 16'h0000);
        rd(5'h02, 16'h0000, "R3 sel0 clear");
        pads("R3 select gates");

        // R9 write to an input pin is hidden until it becomes output
        wr(5'h1C, 16'hAAAB);
        rd(5'h1C, 16'hAA54, "R9 input pin hides latch");
        wr(5'h05, 16'h00FE);
        rd(5'h1C, 16'hAA55, "R9 latch revealed");
        wr(5'h02, 16'hFFFF);
        pads("R9 pin0 driven");

        // R10 unimplemented writes ignored
        wr(5'h10, 16'hFFFF);
        wr(5'h1F, 16'hFFFF);
        rd(5'h10, 16'h0000, "R10 idx10");
        rd(5'h1F, 16'h0000, "R10 idx1F");
        rd(5'h05, 16'h00FE, "R10 dir0 kept");
        rd(5'h1E, 16'h001F, "R10 data2 kept");
        pads("R10 pads kept");

        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        rd(5'h04, 16'h03E0, "R1 rerun sel2");
        rd(5'h06, 16'hFFFF, "R1 rerun dir1");
        rd(5'h00, 16'h0000, "R1 rerun ctrl");
        pads("R1 rerun");

        summary();
    end
endmodule